// File: doc/BRIEF.md
# Frame-Delineated Sample Deframer and Framer

This block sits between the I/O capture flops of a narrow source-synchronous converter bus and the per-channel sample streams of the core. On receive it takes the data and frame strobe captured on the rising and on the falling edge of the interface clock, presented as two single-rate buses on the core clock. It finds the start of each sample group from the frame strobe and hands out one 16-bit I and one 16-bit Q word per channel pair, together with a valid strobe. On transmit it does the opposite. It reads one I/Q set per channel pair, cuts each word down to the converter width and spreads the samples over the rising-edge and falling-edge lane buses. It also drives the matching frame strobe.

Two static settings choose the bus layout. In double-edge mode every sample takes two edges, upper half first. In single-edge mode every sample takes one edge over the full lane width. The single-pair setting shortens every frame to one I/Q sample pair. The receive side locks once, on the first frame start after reset. From then on it checks every strobe edge against the expected pattern and keeps a sticky flag if the pattern is ever broken. Both settings may only change while reset is held.

Top module: `frm_sample_deframer`

## Requirements
- R1: In double-edge mode (`edge_single`=0) each core clock carries one sample: the rising-edge lanes [SAMPLE_W/2-1:0] hold its upper half, the falling-edge lanes [SAMPLE_W/2-1:0] hold its lower half, and lanes above SAMPLE_W/2 are ignored.
- R2: In single-edge mode (`edge_single`=1) each core clock carries two full-width samples, the rising-edge slot holding the earlier one.
- R3: A frame of S samples lasts C core clocks (2C edges). The frame strobe is high on the first C edges and low on the rest. Samples are assigned strictly in arrival order from the frame start as I0, Q0, I1, Q1.
- R4: Each received sample is sign-extended from SAMPLE_W to 16 bits on `rx_i`/`rx_q`.
- R5: One clock after the core clock that carries a frame's last edges, `rx_valid` is high for exactly one cycle on every active channel together. With two pairs in double-edge mode this happens once every 4 clocks.
- R6: With `pair_mode`=1 a frame holds only I0 and Q0, its length and strobe pattern halve, and `rx_valid[1]` never rises.
- R7: Receive capture begins only at a frame start, where the rising-edge strobe is high and the previous falling-edge strobe was low. Before that no valid is produced.
- R8: After lock, any strobe edge that departs from the R3 pattern sets `rx_err`, which stays set until reset.
- R9: The transmit lanes carry the most significant SAMPLE_W bits of each 16-bit input with the same slot order, edge split and strobe pattern as R1 to R3.
- R10: `tx_req` is high in the first clock of each transmit frame, once per frame. The inputs are sampled in that clock, and the frame's first edge pair appears on the lanes in the following clock.
- R11: While reset is held, `rx_valid`, `rx_err`, `rx_i`, `rx_q` and all transmit lane and strobe outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one per edge pair |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_single | input | 1 | 1: one sample per edge; 0: two edges per sample |
| pair_mode | input | 1 | 1: a single I/Q channel pair per frame |
| rx_rise_data | input | SAMPLE_W | Lanes captured on the rising edge |
| rx_fall_data | input | SAMPLE_W | Lanes captured on the falling edge |
| rx_rise_frame | input | 1 | Frame strobe captured on the rising edge |
| rx_fall_frame | input | 1 | Frame strobe captured on the falling edge |
| rx_i | output | NCH x 16 | Received I sample per channel pair |
| rx_q | output | NCH x 16 | Received Q sample per channel pair |
| rx_valid | output | NCH | Per-channel sample strobe |
| rx_err | output | 1 | Sticky frame pattern error |
| tx_i | input | NCH x 16 | I sample per channel pair to send |
| tx_q | input | NCH x 16 | Q sample per channel pair to send |
| tx_req | output | 1 | Transmit inputs are taken in this clock |
| tx_rise_data | output | SAMPLE_W | Lanes for the rising edge |
| tx_fall_data | output | SAMPLE_W | Lanes for the falling edge |
| tx_rise_frame | output | 1 | Frame strobe for the rising edge |
| tx_fall_frame | output | 1 | Frame strobe for the falling edge |

## Verification
A wrong receive phase count shows up at the end of the first frame: samples land on the wrong channel or word half, and the valid strobe comes early, late or twice within one frame. A lost lock or a stale strobe check shows up in `rx_err`. It either rises on clean traffic or stays low after a corrupted edge, and the bench reads it after every frame. On transmit, a mis-set slot counter breaks the strobe pattern or the lane content within one frame of the request strobe, and the bench compares it edge by edge.

// File: rtl/frm_pkg.sv
package frm_pkg;
  // width of the per-channel sample words on the core side
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/frm_rst_sync.sv
module frm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/frm_rx_deframer.sv
module frm_rx_deframer
  import frm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned NCH      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          edge_single,
  input  logic                          pair_mode,
  input  logic [SAMPLE_W-1:0]           rise_d,
  input  logic [SAMPLE_W-1:0]           fall_d,
  input  logic                          rise_f,
  input  logic                          fall_f,
  output logic [NCH-1:0][WORD_W-1:0]    smp_i,
  output logic [NCH-1:0][WORD_W-1:0]    smp_q,
  output logic [NCH-1:0]                smp_vld,
  output logic                          frm_err
);
  localparam int unsigned HALF_W = SAMPLE_W / 2;
  localparam int unsigned SLOTS  = 2 * NCH;
  localparam int unsigned PH_W   = $clog2(4 * NCH);

  logic                              locked_q, locked_n;
  logic [PH_W-1:0]                   phase_q, phase_n;
  logic                              pfall_q;
  logic [SLOTS-1:0][SAMPLE_W-1:0]    slot_q, slot_n;
  logic                              err_q, err_n;
  logic [NCH-1:0][WORD_W-1:0]        i_q, i_n, q_q, q_n;
  logic [NCH-1:0]                    vld_q, vld_n;

  logic [PH_W-1:0] act, nclk, cur;
  logic [PH_W:0]   p2, p2o, nclk_x;
  logic            start, run, last, exp_r, exp_f, bad;

  always_comb begin
    act    = pair_mode ? PH_W'(1) : PH_W'(NCH);
    nclk   = edge_single ? act : (act << 1);
    start  = rise_f & ~pfall_q;
    run    = locked_q | start;
    cur    = locked_q ? phase_q : '0;
    p2     = {cur, 1'b0};
    p2o    = {cur, 1'b1};
    nclk_x = {1'b0, nclk};
    exp_r  = (p2 < nclk_x);
    exp_f  = (p2o < nclk_x);
    last   = run && (cur == nclk - PH_W'(1));
    bad    = run && ((rise_f != exp_r) || (fall_f != exp_f));

    locked_n = locked_q | start;
    err_n    = err_q | bad;
    phase_n  = phase_q;
    if (run) phase_n = last ? '0 : cur + PH_W'(1);

    for (int s = 0; s < SLOTS; s++) begin
      slot_n[s] = slot_q[s];
      if (run) begin
        if (edge_single) begin
          if (p2 == (PH_W+1)'(s))  slot_n[s] = rise_d;
          if (p2o == (PH_W+1)'(s)) slot_n[s] = fall_d;
        end else if (cur == PH_W'(s)) begin
          slot_n[s] = {rise_d[HALF_W-1:0], fall_d[HALF_W-1:0]};
        end
      end
    end

    for (int c = 0; c < NCH; c++) begin
      vld_n[c] = last && (PH_W'(c) < act);
      i_n[c]   = i_q[c];
      q_n[c]   = q_q[c];
      if (vld_n[c]) begin
        i_n[c] = WORD_W'(signed'(slot_n[2*c]));
        q_n[c] = WORD_W'(signed'(slot_n[2*c+1]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      phase_q  <= '0;
      pfall_q  <= 1'b0;
      slot_q   <= '0;
      err_q    <= 1'b0;
      i_q      <= '0;
      q_q      <= '0;
      vld_q    <= '0;
    end else begin
      locked_q <= locked_n;
      phase_q  <= phase_n;
      pfall_q  <= fall_f;
      err_q    <= err_n;
      vld_q    <= vld_n;
      if (run)  slot_q <= slot_n;
      if (last) begin
        i_q <= i_n;
        q_q <= q_n;
      end
    end
  end

  assign smp_i   = i_q;
  assign smp_q   = q_q;
  assign smp_vld = vld_q;
  assign frm_err = err_q;
endmodule

// File: rtl/frm_tx_framer.sv
module frm_tx_framer
  import frm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned NCH      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          edge_single,
  input  logic                          pair_mode,
  input  logic [NCH-1:0][WORD_W-1:0]    src_i,
  input  logic [NCH-1:0][WORD_W-1:0]    src_q,
  output logic                          rd_req,
  output logic [SAMPLE_W-1:0]           rise_d,
  output logic [SAMPLE_W-1:0]           fall_d,
  output logic                          rise_f,
  output logic                          fall_f
);
  localparam int unsigned HALF_W = SAMPLE_W / 2;
  localparam int unsigned SLOTS  = 2 * NCH;
  localparam int unsigned PH_W   = $clog2(4 * NCH);

  logic [PH_W-1:0]                ph_q, ph_n;
  logic [SLOTS-1:0][SAMPLE_W-1:0] hold_q, fresh, cur_src;
  logic [SAMPLE_W-1:0]            rise_q, rise_n, fall_q, fall_n;
  logic                           rf_q, rf_n, ff_q, ff_n;

  logic [PH_W-1:0] act, nclk;
  logic [PH_W:0]   p2, p2o, nclk_x;

  always_comb begin
    act    = pair_mode ? PH_W'(1) : PH_W'(NCH);
    nclk   = edge_single ? act : (act << 1);
    p2     = {ph_q, 1'b0};
    p2o    = {ph_q, 1'b1};
    nclk_x = {1'b0, nclk};
    rd_req = (ph_q == '0);

    for (int c = 0; c < NCH; c++) begin
      fresh[2*c]   = src_i[c][WORD_W-1 -: SAMPLE_W];
      fresh[2*c+1] = src_q[c][WORD_W-1 -: SAMPLE_W];
    end
    cur_src = rd_req ? fresh : hold_q;

    rise_n = '0;
    fall_n = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (edge_single) begin
        if (p2 == (PH_W+1)'(s))  rise_n = cur_src[s];
        if (p2o == (PH_W+1)'(s)) fall_n = cur_src[s];
      end else if (ph_q == PH_W'(s)) begin
        rise_n = SAMPLE_W'(cur_src[s][SAMPLE_W-1:HALF_W]);
        fall_n = SAMPLE_W'(cur_src[s][HALF_W-1:0]);
      end
    end
    rf_n = (p2 < nclk_x);
    ff_n = (p2o < nclk_x);
    ph_n = (ph_q >= nclk - PH_W'(1)) ? '0 : ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      hold_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      rf_q   <= 1'b0;
      ff_q   <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      rise_q <= rise_n;
      fall_q <= fall_n;
      rf_q   <= rf_n;
      ff_q   <= ff_n;
      if (rd_req) hold_q <= fresh;
    end
  end

  assign rise_d = rise_q;
  assign fall_d = fall_q;
  assign rise_f = rf_q;
  assign fall_f = ff_q;
endmodule

// File: rtl/frm_sample_deframer.sv
module frm_sample_deframer
  import frm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned NCH      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          edge_single,
  input  logic                          pair_mode,
  input  logic [SAMPLE_W-1:0]           rx_rise_data,
  input  logic [SAMPLE_W-1:0]           rx_fall_data,
  input  logic                          rx_rise_frame,
  input  logic                          rx_fall_frame,
  output logic [NCH-1:0][WORD_W-1:0]    rx_i,
  output logic [NCH-1:0][WORD_W-1:0]    rx_q,
  output logic [NCH-1:0]                rx_valid,
  output logic                          rx_err,
  input  logic [NCH-1:0][WORD_W-1:0]    tx_i,
  input  logic [NCH-1:0][WORD_W-1:0]    tx_q,
  output logic                          tx_req,
  output logic [SAMPLE_W-1:0]           tx_rise_data,
  output logic [SAMPLE_W-1:0]           tx_fall_data,
  output logic                          tx_rise_frame,
  output logic                          tx_fall_frame
);
  logic rst_sync_n;

  frm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  frm_rx_deframer #(.SAMPLE_W(SAMPLE_W), .NCH(NCH)) u_rx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .edge_single (edge_single),
    .pair_mode   (pair_mode),
    .rise_d      (rx_rise_data),
    .fall_d      (rx_fall_data),
    .rise_f      (rx_rise_frame),
    .fall_f      (rx_fall_frame),
    .smp_i       (rx_i),
    .smp_q       (rx_q),
    .smp_vld     (rx_valid),
    .frm_err     (rx_err)
  );

  frm_tx_framer #(.SAMPLE_W(SAMPLE_W), .NCH(NCH)) u_tx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .edge_single (edge_single),
    .pair_mode   (pair_mode),
    .src_i       (tx_i),
    .src_q       (tx_q),
    .rd_req      (tx_req),
    .rise_d      (tx_rise_data),
    .fall_d      (tx_fall_data),
    .rise_f      (tx_rise_frame),
    .fall_f      (tx_fall_frame)
  );
endmodule

// File: rtl/frm_sample_deframer_chk.sv
module frm_sample_deframer_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst_sync_n,
  input logic           edge_single,
  input logic           pair_mode,
  input logic [NCH-1:0] rx_valid,
  input logic           rx_err,
  input logic           tx_req,
  input logic           tx_rise_frame
);
  // R5: a frame longer than one clock yields a single-cycle valid
  assert_valid_spacing_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid[0] && !(edge_single && pair_mode)) |=> !rx_valid[0]);

  // R5: every active channel strobes together with channel 0
  assert_valid_aligned_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid[NCH-1] |-> rx_valid[0]);

  // R6: the upper channel stays silent in single-pair mode
  assert_pair_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid[NCH-1] |-> !pair_mode);

  // R8: the pattern error flag never clears on its own
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_err |=> rx_err);

  // R10: the clock after a request carries the frame's first strobe edge
  assert_req_start_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_req |=> tx_rise_frame);
endmodule

bind frm_sample_deframer frm_sample_deframer_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .edge_single   (edge_single),
  .pair_mode     (pair_mode),
  .rx_valid      (rx_valid),
  .rx_err        (rx_err),
  .tx_req        (tx_req),
  .tx_rise_frame (tx_rise_frame)
);

// File: tb/tb_frm_sample_deframer.sv
module tb_frm_sample_deframer;
  localparam int CLK_PERIOD = 10;
  localparam int SW  = 12;
  localparam int NCH = 2;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     edge_single, pair_mode;
  logic [SW-1:0]            rx_rise_data, rx_fall_data;
  logic                     rx_rise_frame, rx_fall_frame;
  logic [NCH-1:0][15:0]     rx_i, rx_q, tx_i, tx_q;
  logic [NCH-1:0]           rx_valid;
  logic                     rx_err, tx_req;
  logic [SW-1:0]            tx_rise_data, tx_fall_data;
  logic                     tx_rise_frame, tx_fall_frame;

  int checks = 0;
  int errors = 0;
  logic [SW-1:0] smp [4];

  // {edge_single, pair_mode, s0, s1, s2, s3}
  localparam logic [49:0] VEC [8] = '{
    {1'b0, 1'b0, 12'h123, 12'h8A5, 12'h7FF, 12'h800},
    {1'b0, 1'b0, 12'hFFF, 12'h001, 12'h5A5, 12'hA5A},
    {1'b1, 1'b0, 12'h321, 12'hC00, 12'h0F0, 12'h9AB},
    {1'b1, 1'b0, 12'h456, 12'h789, 12'hABC, 12'hDEF},
    {1'b0, 1'b1, 12'h812, 12'h034, 12'h000, 12'h000},
    {1'b0, 1'b1, 12'h7A0, 12'hF0F, 12'h000, 12'h000},
    {1'b1, 1'b1, 12'h111, 12'hE22, 12'h000, 12'h000},
    {1'b1, 1'b1, 12'h6CD, 12'h8EF, 12'h000, 12'h000}
  };

  frm_sample_deframer #(.SAMPLE_W(SW), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .edge_single(edge_single), .pair_mode(pair_mode),
    .rx_rise_data(rx_rise_data), .rx_fall_data(rx_fall_data),
    .rx_rise_frame(rx_rise_frame), .rx_fall_frame(rx_fall_frame),
    .rx_i(rx_i), .rx_q(rx_q), .rx_valid(rx_valid), .rx_err(rx_err),
    .tx_i(tx_i), .tx_q(tx_q), .tx_req(tx_req),
    .tx_rise_data(tx_rise_data), .tx_fall_data(tx_fall_data),
    .tx_rise_frame(tx_rise_frame), .tx_fall_frame(tx_fall_frame)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sx(input logic [SW-1:0] v);
    return {{(16-SW){v[SW-1]}}, v};
  endfunction

  function automatic int frame_clocks();
    int a;
    a = pair_mode ? 1 : NCH;
    return edge_single ? a : 2 * a;
  endfunction

  task automatic do_reset(input bit se, input bit pr);
    @(negedge clk);
    rst_n = 1'b0;
    edge_single = se;
    pair_mode = pr;
    rx_rise_frame = 1'b0;
    rx_fall_frame = 1'b0;
    rx_rise_data = '0;
    rx_fall_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // called at a negedge; drives one frame, checks outputs after its last clock
  task automatic send_frame(input int bad_ph);
    int c, vcnt;
    c = frame_clocks();
    vcnt = 0;
    for (int p = 0; p < c; p++) begin
      if (edge_single) begin
        rx_rise_data = smp[2*p];
        rx_fall_data = smp[2*p+1];
      end else begin
        rx_rise_data = {6'h2A, smp[p][SW-1:SW/2]};
        rx_fall_data = {6'h15, smp[p][SW/2-1:0]};
      end
      rx_rise_frame = (2*p < c);
      rx_fall_frame = (2*p+1 < c);
      if (p == bad_ph) rx_rise_frame = ~rx_rise_frame;
      @(posedge clk);
      @(negedge clk);
      if (rx_valid[0]) vcnt++;
    end
    check(vcnt == 1, "R5 valid pulses per frame", vcnt, 1);
    check(rx_i[0] == sx(smp[0]), "R1/R2/R3/R4 I0", rx_i[0], sx(smp[0]));
    check(rx_q[0] == sx(smp[1]), "R1/R2/R3/R4 Q0", rx_q[0], sx(smp[1]));
    check(rx_valid[1] == !pair_mode, "R6 channel 1 valid", rx_valid[1], !pair_mode);
    if (!pair_mode) begin
      check(rx_i[1] == sx(smp[2]), "R3/R4 I1", rx_i[1], sx(smp[2]));
      check(rx_q[1] == sx(smp[3]), "R3/R4 Q1", rx_q[1], sx(smp[3]));
    end
  endtask

  task automatic tx_check();
    int c, cnt;
    bit found, prevf;
    logic [SW-1:0] er, ef;
    c = frame_clocks();
    found = 1'b0;
    prevf = 1'b1;
    for (int k = 0; k < 40 && !found; k++) begin
      @(negedge clk);
      if (tx_rise_frame && !prevf) begin
        found = 1'b1;
        for (int p = 0; p < c; p++) begin
          if (p > 0) @(negedge clk);
          if (edge_single) begin
            er = smp[2*p];
            ef = smp[2*p+1];
          end else begin
            er = {6'h00, smp[p][SW-1:SW/2]};
            ef = {6'h00, smp[p][SW/2-1:0]};
          end
          check(tx_rise_data == er && tx_fall_data == ef, "R9 tx lanes",
                {tx_rise_data, tx_fall_data}, {er, ef});
          check(tx_rise_frame == (2*p < c) && tx_fall_frame == (2*p+1 < c), "R9 tx strobe",
                {tx_rise_frame, tx_fall_frame}, {(2*p < c), (2*p+1 < c)});
        end
      end else begin
        prevf = tx_fall_frame;
      end
    end
    check(found, "R9 tx frame start seen", found, 1);
    cnt = 0;
    for (int k = 0; k < 4 * c; k++) begin
      @(negedge clk);
      if (tx_req) cnt++;
    end
    check(cnt == 4, "R10 tx_req once per frame", cnt, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vcnt;
    rst_n = 1'b0;
    edge_single = 1'b0;
    pair_mode = 1'b0;
    rx_rise_data = '0;
    rx_fall_data = '0;
    rx_rise_frame = 1'b0;
    rx_fall_frame = 1'b0;
    tx_i = '0;
    tx_q = '0;
    repeat (3) @(negedge clk);

    // R11: reset state
    check(rx_valid == '0 && rx_err == 1'b0, "R11 rx flags in reset", {rx_valid, rx_err}, 0);
    check(rx_i == '0 && rx_q == '0, "R11 rx data in reset", {rx_i, rx_q}, 0);
    check(tx_rise_data == '0 && tx_fall_data == '0 && !tx_rise_frame && !tx_fall_frame,
          "R11 tx outputs in reset", {tx_rise_data, tx_fall_data, tx_rise_frame, tx_fall_frame}, 0);

    for (int e = 0; e < 8; e++) begin
      smp[0] = VEC[e][47:36];
      smp[1] = VEC[e][35:24];
      smp[2] = VEC[e][23:12];
      smp[3] = VEC[e][11:0];
      tx_i[0] = {smp[0], 4'h5};
      tx_q[0] = {smp[1], 4'hA};
      tx_i[1] = {smp[2], 4'h3};
      tx_q[1] = {smp[3], 4'hC};
      do_reset(VEC[e][49], VEC[e][48]);
      tx_check();
      send_frame(-1);
      send_frame(-1);
      check(rx_err == 1'b0, "R8 no error on clean frames", rx_err, 0);
    end

    // R7: no start seen, nothing captured
    do_reset(1'b0, 1'b0);
    vcnt = 0;
    for (int k = 0; k < 10; k++) begin
      rx_rise_data = 12'h0FF;
      rx_fall_data = 12'h0AA;
      rx_rise_frame = 1'b0;
      rx_fall_frame = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (rx_valid != '0) vcnt++;
    end
    check(vcnt == 0, "R7 no valid before frame start", vcnt, 0);
    check(rx_err == 1'b0 && rx_i == '0, "R7 no capture before lock", {rx_err, rx_i}, 0);

    // R8: corrupted strobe sets a sticky error
    smp[0] = 12'h0C3; smp[1] = 12'hF3C; smp[2] = 12'h5F0; smp[3] = 12'hA0F;
    send_frame(-1);
    check(rx_err == 1'b0, "R8 clean frame before fault", rx_err, 0);
    send_frame(1);
    check(rx_err == 1'b1, "R8 error after broken strobe", rx_err, 1);
    send_frame(-1);
    check(rx_err == 1'b1, "R8 error stays set", rx_err, 1);
    do_reset(1'b0, 1'b0);
    check(rx_err == 1'b0, "R8 error cleared by reset", rx_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule